// File: doc/BRIEF.md
# Ternary Match Table Access and Search Engine

This block owns a small ternary match table and two companion RAMs, an action RAM and a rate-meter RAM. All three are indexed by the same entry number. Software works through a flat register window. It fills eight 32-bit staging data words and eight 32-bit staging mask words. It then writes one access register that holds an operation code, a RAM selector, an entry address, a start/busy bit and a table-clear bit. The engine carries out the request and drops the busy bit when it is done.

A read copies the selected entry into staging. A write copies staging into the selected entry. A search takes the staged data words as a key and walks the table one entry per cycle from the programmed address. On each hit it stops, copies the matching entry into staging and raises a hit flag. It resumes only after software reads the last data word. The address field always shows the entry under examination. A clear request zeroes every entry of all three RAMs, one entry per cycle.

Register window (word index on `reg_addr`): 0..7 are the staging data words and 8..15 are the staging mask words. Index 16 is the access register: bits [1:0] hold the operation (0 read, 1 write, 2 search), bits [3:2] select the RAM (0 match table, 1 action, 2 meter), bit 4 is start/busy, bit 5 is hit, bit 6 is clear, and bits [8 +: ADDR_W] hold the entry address.

The engine has six states:
- IDLE accepts access-register writes.
- RD_ENT (IDLE→RD_ENT on a start with op read) returns to IDLE after one cycle.
- WR_ENT (IDLE→WR_ENT on a start with op write) returns to IDLE after one cycle.
- SCAN (IDLE→SCAN on a start with op search) has three exits: SCAN→HOLD on a hit, SCAN→SCAN stepping on a miss, and SCAN→IDLE on a miss at the last entry.
- HOLD moves to SCAN (next entry) or to IDLE (after the last entry) when data word 7 is read.
- WIPE (IDLE→WIPE on a clear request) steps through every entry and returns WIPE→IDLE after the last one.

Top module: `tcam_engine`

## Requirements
- R1: After reset, the access register and every staging data and mask word read as zero.
- R2: A write operation stores the staged data and mask words into the match table at the given address, and a read returns them to staging. The start bit reads 1 for exactly one cycle after the access write.
- R3: The action RAM and the meter RAM hold separate data at the same index. A read from either loads only the staging data words and leaves the staging mask words unchanged.
- R4: A write to the access register while an operation or clear is in progress is ignored: fields, address and state are unchanged.
- R5: An entry is a search hit when its word 0 bits [1:0] are nonzero and ((key XOR stored data) AND stored mask) is zero in every bit. The key is the staged data words at search start.
- R6: A search examines entries in ascending order from the programmed address to the last entry, one per cycle. It reports every hit in that order and keeps the start bit at 1 until the last entry has been examined.
- R7: On a hit, the hit bit (bit 5) is set, the address field shows the hit entry, and the staging data and mask words hold that entry. The scan stays stopped until data word 7 is read, then clears the hit bit and resumes.
- R8: Writing the clear bit (bit 6) zeroes every entry in all three RAMs. The clear bit reads 1 for exactly DEPTH cycles, then self-clears.
- R9: Entry 0 is never reported by a search, even when it would match. A search programmed at address 0 starts at entry 1.
- R10: A start with operation code 3, or a read or write with RAM code 3, performs nothing, and the start bit reads 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data word 7 only) |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
A corrupted scan pointer or state shows at once in the access register. A wrong hit address, or a hit bit that appears or vanishes, can be seen in the cycle after the entry is examined. Lost or spurious hits are caught by comparing the ordered hit list of each search against an independent table model. Wrong RAM steering shows on the next read-back as data from the wrong RAM, or as mask words that moved when they should not have. A clear that ends early or late is caught by counting the cycles during which the clear bit is set.

// File: rtl/tcam_eng_pkg.sv
package tcam_eng_pkg;

    localparam int WORD_W      = 32;
    localparam int AC_OP_LSB   = 0;
    localparam int AC_SEL_LSB  = 2;
    localparam int AC_START    = 4;
    localparam int AC_HIT      = 5;
    localparam int AC_CLEAR    = 6;
    localparam int AC_ADDR_LSB = 8;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_SEARCH = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SEL_MATCH  = 2'd0,
        SEL_ACTION = 2'd1,
        SEL_METER  = 2'd2,
        SEL_RSVD   = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_RD_ENT = 3'd1,
        S_WR_ENT = 3'd2,
        S_SCAN   = 3'd3,
        S_HOLD   = 3'd4,
        S_WIPE   = 3'd5
    } state_e;

endpackage

// File: rtl/tcam_array.sv
module tcam_array
    import tcam_eng_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int WORDS  = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             idx,
    input  logic [WORDS-1:0][WORD_W-1:0]  wdata,
    input  logic [WORDS-1:0][WORD_W-1:0]  wmask,
    input  logic [WORDS-1:0][WORD_W-1:0]  key,
    output logic [WORDS-1:0][WORD_W-1:0]  rdata,
    output logic [WORDS-1:0][WORD_W-1:0]  rmask,
    output logic                          hit
);

    logic [WORDS-1:0][WORD_W-1:0] dmem [DEPTH];
    logic [WORDS-1:0][WORD_W-1:0] mmem [DEPTH];
    logic                          valid;

    always_ff @(posedge clk) begin
        if (we) begin
            dmem[idx] <= wdata;
            mmem[idx] <= wmask;
        end
    end

    assign rdata = dmem[idx];
    assign rmask = mmem[idx];

    // slice-valid field lives in the low two bits of word 0
    assign valid = |rdata[0][1:0];
    assign hit   = valid && (((key ^ rdata) & rmask) == '0);

endmodule

// File: rtl/side_ram.sv
module side_ram
    import tcam_eng_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int WORDS  = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             idx,
    input  logic [WORDS-1:0][WORD_W-1:0]  wdata,
    output logic [WORDS-1:0][WORD_W-1:0]  rdata
);

    logic [WORDS-1:0][WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/tcam_eng_fsm.sv
module tcam_eng_fsm
    import tcam_eng_pkg::*;
#(
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic [1:0]        acc_op,
    input  logic [1:0]        acc_sel,
    input  logic              acc_start,
    input  logic              acc_clr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              eng_hit,
    input  logic              rel,
    output state_e            st,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        op_q,
    output logic [1:0]        sel_q,
    output logic [2:0]        we_vec,
    output logic              ld_data,
    output logic              ld_mask,
    output logic [1:0]        ld_src,
    output logic              key_cap
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    state_e nxt;
    logic   go;
    logic   at_last;

    assign go      = acc_wr && (st == S_IDLE);
    assign at_last = (cur_addr == LAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: begin
                if (go) begin
                    if (acc_clr) begin
                        nxt = S_WIPE;
                    end else if (acc_start) begin
                        if (acc_op == OP_READ && acc_sel != SEL_RSVD) begin
                            nxt = S_RD_ENT;
                        end else if (acc_op == OP_WRITE && acc_sel != SEL_RSVD) begin
                            nxt = S_WR_ENT;
                        end else if (acc_op == OP_SEARCH) begin
                            nxt = S_SCAN;
                        end
                    end
                end
            end
            S_RD_ENT: nxt = S_IDLE;
            S_WR_ENT: nxt = S_IDLE;
            S_SCAN: begin
                if (eng_hit) begin
                    nxt = S_HOLD;
                end else if (at_last) begin
                    nxt = S_IDLE;
                end
            end
            S_HOLD: begin
                if (rel) begin
                    nxt = at_last ? S_IDLE : S_SCAN;
                end
            end
            S_WIPE: begin
                if (at_last) begin
                    nxt = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // address pointer and latched request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            op_q     <= '0;
            sel_q    <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (acc_wr) begin
                        op_q  <= acc_op;
                        sel_q <= acc_sel;
                        if (acc_clr) begin
                            cur_addr <= '0;
                        end else if (acc_start && acc_op == OP_SEARCH && acc_addr == '0) begin
                            cur_addr <= ADDR_W'(1);
                        end else begin
                            cur_addr <= acc_addr;
                        end
                    end
                end
                S_SCAN: begin
                    if (!eng_hit && !at_last) begin
                        cur_addr <= cur_addr + 1'b1;
                    end
                end
                S_HOLD: begin
                    if (rel && !at_last) begin
                        cur_addr <= cur_addr + 1'b1;
                    end
                end
                S_WIPE: begin
                    if (!at_last) begin
                        cur_addr <= cur_addr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        we_vec[0] = (st == S_WR_ENT && sel_q == SEL_MATCH)  || (st == S_WIPE);
        we_vec[1] = (st == S_WR_ENT && sel_q == SEL_ACTION) || (st == S_WIPE);
        we_vec[2] = (st == S_WR_ENT && sel_q == SEL_METER)  || (st == S_WIPE);
        ld_data   = (st == S_RD_ENT) || (st == S_SCAN && eng_hit);
        ld_mask   = (st == S_RD_ENT && sel_q == SEL_MATCH) || (st == S_SCAN && eng_hit);
        ld_src    = (st == S_SCAN) ? SEL_MATCH : sel_q;
        key_cap   = go && acc_start && !acc_clr && (acc_op == OP_SEARCH);
    end

endmodule

// File: rtl/tcam_engine.sv
module tcam_engine
    import tcam_eng_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int WORDS  = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int IDX_W  = $clog2(WORDS),
    localparam int RA_W   = $clog2(2 * WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    localparam logic [RA_W-1:0] ACC_IDX = RA_W'(2 * WORDS);
    localparam logic [RA_W-1:0] LAST_DW = RA_W'(WORDS - 1);

    logic [WORDS-1:0][WORD_W-1:0] stg_d, stg_m, key_q;
    logic [WORDS-1:0][WORD_W-1:0] wr_d, wr_m;
    logic [WORDS-1:0][WORD_W-1:0] tc_d, tc_m, src_d;
    logic [WORDS-1:0][WORD_W-1:0] side_rd [2];

    state_e            st;
    logic [ADDR_W-1:0] cur_addr;
    logic [1:0]        op_q, sel_q, ld_src;
    logic [2:0]        we_vec;
    logic              ld_data, ld_mask, key_cap;
    logic              eng_hit, rel, acc_wr, wiping;
    logic              in_data, in_mask;
    logic [31:0]       acc_rd;

    assign acc_wr  = reg_wr && (reg_addr == ACC_IDX);
    assign rel     = reg_rd && (reg_addr == LAST_DW);
    assign in_data = reg_addr < RA_W'(WORDS);
    assign in_mask = !in_data && (reg_addr < ACC_IDX);
    assign wiping  = (st == S_WIPE);

    tcam_eng_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_wr   (acc_wr),
        .acc_op   (reg_wdata[AC_OP_LSB +: 2]),
        .acc_sel  (reg_wdata[AC_SEL_LSB +: 2]),
        .acc_start(reg_wdata[AC_START]),
        .acc_clr  (reg_wdata[AC_CLEAR]),
        .acc_addr (reg_wdata[AC_ADDR_LSB +: ADDR_W]),
        .eng_hit  (eng_hit),
        .rel      (rel),
        .st       (st),
        .cur_addr (cur_addr),
        .op_q     (op_q),
        .sel_q    (sel_q),
        .we_vec   (we_vec),
        .ld_data  (ld_data),
        .ld_mask  (ld_mask),
        .ld_src   (ld_src),
        .key_cap  (key_cap)
    );

    assign wr_d = wiping ? '0 : stg_d;
    assign wr_m = wiping ? '0 : stg_m;

    tcam_array #(.DEPTH(DEPTH), .WORDS(WORDS)) u_tcam (
        .clk  (clk),
        .we   (we_vec[0]),
        .idx  (cur_addr),
        .wdata(wr_d),
        .wmask(wr_m),
        .key  (key_q),
        .rdata(tc_d),
        .rmask(tc_m),
        .hit  (eng_hit)
    );

    for (genvar g = 0; g < 2; g++) begin : g_side
        side_ram #(.DEPTH(DEPTH), .WORDS(WORDS)) u_ram (
            .clk  (clk),
            .we   (we_vec[g+1]),
            .idx  (cur_addr),
            .wdata(wr_d),
            .rdata(side_rd[g])
        );
    end

    always_comb begin
        unique case (ld_src)
            SEL_ACTION: src_d = side_rd[0];
            SEL_METER:  src_d = side_rd[1];
            default:    src_d = tc_d;
        endcase
    end

    // staging registers: engine loads take priority over bus writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_d <= '0;
            stg_m <= '0;
            key_q <= '0;
        end else begin
            if (ld_data) begin
                stg_d <= src_d;
            end else if (reg_wr && in_data) begin
                stg_d[reg_addr[IDX_W-1:0]] <= reg_wdata;
            end
            if (ld_mask) begin
                stg_m <= tc_m;
            end else if (reg_wr && in_mask) begin
                stg_m[reg_addr[IDX_W-1:0]] <= reg_wdata;
            end
            if (key_cap) begin
                key_q <= stg_d;
            end
        end
    end

    always_comb begin
        acc_rd = '0;
        acc_rd[AC_OP_LSB +: 2]        = op_q;
        acc_rd[AC_SEL_LSB +: 2]       = sel_q;
        acc_rd[AC_START]              = (st == S_RD_ENT) || (st == S_WR_ENT) ||
                                        (st == S_SCAN)   || (st == S_HOLD);
        acc_rd[AC_HIT]                = (st == S_HOLD);
        acc_rd[AC_CLEAR]              = wiping;
        acc_rd[AC_ADDR_LSB +: ADDR_W] = cur_addr;
    end

    always_comb begin
        if (in_data) begin
            reg_rdata = stg_d[reg_addr[IDX_W-1:0]];
        end else if (in_mask) begin
            reg_rdata = stg_m[reg_addr[IDX_W-1:0]];
        end else if (reg_addr == ACC_IDX) begin
            reg_rdata = acc_rd;
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/tcam_engine_chk.sv
module tcam_engine_chk
    import tcam_eng_pkg::*;
#(
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input state_e            st,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              eng_hit,
    input logic              rel,
    input logic              acc_wr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    // R2
    rw_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RD_ENT || st == S_WR_ENT) |=> st == S_IDLE);

    // R6
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SCAN && !eng_hit && cur_addr != LAST) |=>
        (st == S_SCAN && cur_addr == $past(cur_addr) + 1'b1));

    // R6
    scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SCAN && !eng_hit && cur_addr == LAST) |=> st == S_IDLE);

    // R7
    hit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SCAN && eng_hit) |=> (st == S_HOLD && $stable(cur_addr)));

    // R7
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HOLD && !rel) |=> (st == S_HOLD && $stable(cur_addr)));

    // R9
    no_zero_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_HOLD |-> cur_addr != '0);

    // R4
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HOLD && acc_wr && !rel) |=> (st == S_HOLD && $stable(cur_addr)));

    // R8
    wipe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WIPE && cur_addr == LAST) |=> st == S_IDLE);

endmodule

bind tcam_engine tcam_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .cur_addr(cur_addr),
    .eng_hit (eng_hit),
    .rel     (rel),
    .acc_wr  (acc_wr)
);

// File: tb/tcam_engine_test.sv
`timescale 1ns/100ps
module tcam_engine_test;

    localparam int DEPTH = 32;
    localparam int W     = 8;
    localparam int EW    = 32 * W;
    localparam int RA_W  = $clog2(2 * W + 1);
    localparam int ACC   = 2 * W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [RA_W-1:0] reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;

    int total = 0;
    int bad   = 0;

    logic [EW-1:0] mdat [DEPTH];
    logic [EW-1:0] mmsk [DEPTH];
    logic [EW-1:0] mact [DEPTH];
    logic [EW-1:0] mmet [DEPTH];

    tcam_engine #(.DEPTH(DEPTH), .WORDS(W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = RA_W'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rdw(input int a, output logic [31:0] d);
        reg_addr = RA_W'(a);
        #0.1;
        d = reg_rdata;
    endtask

    task automatic release7();
        reg_rd = 1'b1; reg_addr = RA_W'(W - 1);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic stage(input logic [EW-1:0] d, input logic [EW-1:0] m);
        for (int i = 0; i < W; i++) wr(i, d[i*32 +: 32]);
        for (int i = 0; i < W; i++) wr(W + i, m[i*32 +: 32]);
    endtask

    task automatic grab(output logic [EW-1:0] d, output logic [EW-1:0] m);
        logic [31:0] t;
        for (int i = 0; i < W; i++) begin rdw(i, t); d[i*32 +: 32] = t; end
        for (int i = 0; i < W; i++) begin rdw(W + i, t); m[i*32 +: 32] = t; end
    endtask

    function automatic logic [31:0] acc_word(int op, int sel, bit start, bit clr, int a);
        logic [31:0] v = '0;
        v[1:0] = 2'(op); v[3:2] = 2'(sel); v[4] = start; v[6] = clr;
        v[8 +: 5] = 5'(a);
        return v;
    endfunction

    task automatic wait_idle();
        logic [31:0] a;
        rdw(ACC, a);
        while (a[4] || a[6]) begin
            @(posedge clk); #1;
            rdw(ACC, a);
        end
    endtask

    task automatic do_op(input int op, input int sel, input int a);
        wr(ACC, acc_word(op, sel, 1'b1, 1'b0, a));
        wait_idle();
    endtask

    function automatic int next_hit(int from, logic [EW-1:0] key);
        for (int a = from; a < DEPTH; a++) begin
            if (a != 0 && mdat[a][1:0] != 2'b00 && ((key ^ mdat[a]) & mmsk[a]) == '0)
                return a;
        end
        return -1;
    endfunction

    task automatic run_search(input logic [EW-1:0] key, input int start, input bit poke);
        logic [31:0]   a;
        logic [EW-1:0] d, m;
        int exp = next_hit(start == 0 ? 1 : start, key);
        int guard = 0;
        stage(key, '0);
        wr(ACC, acc_word(2, 0, 1'b1, 1'b0, start));
        forever begin
            @(posedge clk); #1;
            guard++;
            rdw(ACC, a);
            if (a[5]) begin
                chk(a[12:8] == 5'(exp), "R6 hit order / R9 entry 0 skipped", EW'(a[12:8]), EW'(exp));
                grab(d, m);
                chk(d == mdat[exp], "R7 hit data staged (R5 match rule)", d, mdat[exp]);
                chk(m == mmsk[exp], "R7 hit mask staged", m, mmsk[exp]);
                if (poke) begin
                    poke = 1'b0;
                    repeat (3) @(posedge clk);
                    #1;
                    rdw(ACC, a);
                    chk(a[5] && a[12:8] == 5'(exp), "R7 scan held until word 7 read", EW'(a), EW'(exp));
                    wr(ACC, acc_word(1, 0, 1'b1, 1'b1, 0));
                    rdw(ACC, a);
                    chk(a[5] && !a[6] && a[12:8] == 5'(exp) && a[1:0] == 2'd2,
                        "R4 access write ignored while busy", EW'(a), EW'(exp));
                end
                release7();
                rdw(ACC, a);
                chk(!a[5], "R7 hit bit clears after word 7 read", EW'(a[5]), 0);
                exp = next_hit(exp + 1, key);
            end else if (!a[4]) begin
                break;
            end
            if (guard > 4 * DEPTH) break;
        end
        chk(exp == -1, "R6 all hits reported before start bit clears", EW'(exp), EW'(-1));
    endtask

    initial begin
        logic [31:0]   a;
        logic [EW-1:0] d, m, k, pat;
        int            n, idx;
        void'($urandom(32'h0005eed5));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R1 reset state
        rdw(ACC, a);
        chk(a == 0, "R1 access reg after reset", EW'(a), 0);
        grab(d, m);
        chk(d == '0 && m == '0, "R1 staging after reset", d | m, 0);

        // R8 clear timing
        wr(ACC, acc_word(0, 0, 1'b0, 1'b1, 0));
        n = 0;
        rdw(ACC, a);
        while (a[6] && n < 10 * DEPTH) begin
            @(posedge clk); #1; n++;
            rdw(ACC, a);
        end
        chk(n == DEPTH, "R8 clear bit duration", EW'(n), EW'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            mdat[i] = '0; mmsk[i] = '0; mact[i] = '0; mmet[i] = '0;
        end

        // R2 busy timing on one write
        stage({EW/32{32'hA5A5_0001}}, {EW/32{32'h0F0F_F0F0}});
        wr(ACC, acc_word(1, 0, 1'b1, 1'b0, 7));
        rdw(ACC, a);
        chk(a[4] == 1'b1, "R2 start bit set one cycle", EW'(a), 1);
        @(posedge clk); #1;
        rdw(ACC, a);
        chk(a[4] == 1'b0, "R2 start bit cleared after one cycle", EW'(a), 0);
        mdat[7] = {EW/32{32'hA5A5_0001}}; mmsk[7] = {EW/32{32'h0F0F_F0F0}};

        // entry 0 programmed to match anything (R9)
        d = '0; d[0 +: 2] = 2'b11;
        stage(d, '0);
        do_op(1, 0, 0);
        mdat[0] = d; mmsk[0] = '0;

        // random match table contents
        for (int e = 0; e < 40; e++) begin
            idx = 1 + ($urandom % (DEPTH - 1));
            for (int i = 0; i < W; i++) d[i*32 +: 32] = $urandom;
            m = '0;
            m[32 +: 32] = 32'h3;
            if (($urandom % 4) == 0) m[64 +: 32] = 32'h1;
            stage(d, m);
            do_op(1, 0, idx);
            mdat[idx] = d; mmsk[idx] = m;
        end
        for (int r = 0; r < 6; r++) begin
            idx = $urandom % DEPTH;
            do_op(0, 0, idx);
            grab(d, m);
            chk(d == mdat[idx] && m == mmsk[idx], "R2 match table read-back", d, mdat[idx]);
        end

        // R3 side RAMs at shared indices
        for (int r = 0; r < 4; r++) begin
            idx = $urandom % DEPTH;
            for (int i = 0; i < W; i++) d[i*32 +: 32] = $urandom;
            stage(d, '0); do_op(1, 1, idx); mact[idx] = d;
            for (int i = 0; i < W; i++) d[i*32 +: 32] = $urandom;
            stage(d, '0); do_op(1, 2, idx); mmet[idx] = d;
            pat = {EW/32{32'hC3C3_3C3C}};
            stage('0, pat);
            do_op(0, 1, idx);
            grab(d, m);
            chk(d == mact[idx], "R3 action RAM read-back", d, mact[idx]);
            chk(m == pat, "R3 mask staging untouched by side read", m, pat);
            do_op(0, 2, idx);
            grab(d, m);
            chk(d == mmet[idx], "R3 meter RAM read-back", d, mmet[idx]);
        end

        // R10 reserved codes
        wr(ACC, acc_word(3, 0, 1'b1, 1'b0, 9));
        @(posedge clk); #1;
        rdw(ACC, a);
        chk(a[4] == 1'b0, "R10 reserved op does nothing", EW'(a), 0);
        stage({EW/32{32'hDEAD_BEEF}}, {EW/32{32'hFFFF_FFFF}});
        wr(ACC, acc_word(1, 3, 1'b1, 1'b0, 9));
        @(posedge clk); #1;
        rdw(ACC, a);
        chk(a[4] == 1'b0, "R10 reserved RAM start bit", EW'(a), 0);
        do_op(0, 0, 9);
        grab(d, m);
        chk(d == mdat[9] && m == mmsk[9], "R10 reserved RAM left table unchanged", d, mdat[9]);

        // directed: valid-cleared entry that would match everything (R5)
        d = '0; stage(d, '0); do_op(1, 0, 3);
        mdat[3] = '0; mmsk[3] = '0;

        // searches (R5 R6 R7 R9)
        for (int s = 0; s < 8; s++) begin
            k = '0;
            k[32 +: 32] = 32'($urandom % 4);
            k[64 +: 32] = 32'($urandom % 2);
            run_search(k, (s < 4) ? 0 : ($urandom % DEPTH), s == 0);
        end

        // R4 during clear, then R8 contents zeroed
        stage({EW/32{32'h1234_5678}}, {EW/32{32'hFFFF_FFFF}});
        wr(ACC, acc_word(0, 0, 1'b0, 1'b1, 0));
        wr(ACC, acc_word(1, 0, 1'b1, 1'b0, 5));
        wait_idle();
        for (int i = 0; i < DEPTH; i++) begin
            mdat[i] = '0; mmsk[i] = '0;
        end
        do_op(0, 0, 5);
        grab(d, m);
        chk(d == '0 && m == '0, "R4 write during clear ignored / R8 entry zeroed", d | m, 0);
        do_op(0, 1, idx);
        grab(d, m);
        chk(d == '0, "R8 action entry zeroed", d, 0);
        run_search('0, 1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule